// File: doc/BRIEF.md
# Floppy Disk State Sequencer

This block is the bit engine of a floppy disk controller whose behaviour is defined by a program ROM outside the block. It holds a 4-bit sequencer state and an 8-bit shift register. On every enabled tick it builds an 8-bit address for the ROM, and the ROM answers with a byte. The low nibble of that byte is a command for the shift register. The high nibble is the next sequencer state.

The address is formed from these inputs:
- the state bits, placed in a fixed scrambled order;
- a one-tick flag that marks a fresh rising edge of the disk read pulse;
- two mode bits, a load/sense mode and a write mode;
- the shift register's top bit.

The ROM program can therefore assemble bytes while reading, shift bytes out while writing, and sense the write-protect line. A byte read from disk is complete when the top bit of the register becomes 1.

The sequencer advances only when two inputs are high at a clock edge: the 2 MHz tick qualifier and the motor-on signal. When the motor is off, the state is forced to zero. The host reads the register over a shared bus that the block drives only when it is selected at an even address.

Top module: `diskSequencer`

## Requirements
- R1: After reset, the following all read zero: the state, the shift register, both pulse detector flops and the illegal-command flag.
- R2: The ROM address `romAddr` is built as follows. Bit 0 is state[1]. Bit 1 is the shift register's bit 7. Bit 2 is `modeLoad`. Bit 3 is `modeWrite`. Bit 4 is the inverse of the pulse-edge flag. Bit 5 is state[0]. Bit 6 is state[2]. Bit 7 is state[3].
- R3: On an enabled edge, the state takes the value of `romData[7:4]`.
- R4: On an enabled edge, the command in `romData[3:0]` acts on the shift register as follows. Code 0x0 clears it. Code 0x8 leaves it unchanged. Code 0x9 shifts it left and inserts 0. Code 0xD shifts it left and inserts 1.
- R5: Code 0xA shifts the register right, and `writeProtect` enters bit 7.
- R6: Code 0xB loads the register from `busIn`.
- R7: Codes 0x1 to 0x7, 0xC, 0xE and 0xF leave the register unchanged. After an enabled edge that carried one of these codes, `illegalCmd` is high for exactly one clock.
- R8: An edge is enabled only when `clkQual` and `motorOn` are both high. On any other edge, the shift register and the detector flops keep their values. While `motorOn` is low, the state becomes zero at every edge.
- R9: The detector samples `readPulse` into two flops in series on enabled edges. The edge flag is the first flop AND NOT the second flop. So after the first enabled edge that sees the pulse high, `romAddr[4]` reads 0 until the next enabled edge.
- R10: `busOut` carries the shift register when `devSelect` is high and `addrLsb` is low. Otherwise it is high impedance.
- R11: `writeData` equals state[3] AND `modeWrite`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkQual | input | 1 | 2 MHz tick qualifier |
| motorOn | input | 1 | Drive motor on |
| readPulse | input | 1 | Raw read pulse from the disk |
| writeProtect | input | 1 | Serial write-protect sense |
| modeLoad | input | 1 | Load/sense mode bit |
| modeWrite | input | 1 | Write mode bit |
| devSelect | input | 1 | Device select from the host |
| addrLsb | input | 1 | Host address bit 0 |
| busIn | input | 8 | Host data for parallel load |
| busOut | output | 8 | Tri-stated register read-back |
| romAddr | output | 8 | Program ROM address |
| romData | input | 8 | Program ROM data |
| writeData | output | 1 | Write signal to the drive |
| illegalCmd | output | 1 | Unused command seen |

## Verification
The hardest situation to reach from the ports is one in which every state, command code and address combination meets every gating case. This includes a pulse edge that lands exactly when the qualifier is low, and a motor-off reset that falls in the middle of a program. The bench fills the ROM with an arithmetic hash, so that all sixteen command codes and all next states occur. It then drives the inputs from interleaved counter patterns whose periods are coprime, so these collisions happen many times. A reference model in the bench predicts the address, the register (read back over the bus), the write output and the flag on every cycle.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  localparam int STATE_W = 4;
  localparam int SHIFT_W = 8;
  localparam int ROM_AW  = 8;

  typedef enum logic [3:0] {
    CMD_CLR  = 4'h0,
    CMD_HOLD = 4'h8,
    CMD_SL0  = 4'h9,
    CMD_SHR  = 4'hA,
    CMD_LOAD = 4'hB,
    CMD_SL1  = 4'hD
  } seqCmd_e;

  typedef struct packed {
    logic clr;
    logic shl;
    logic shr;
    logic load;
    logic ins;
    logic illegal;
  } seqStrobe_t;
endpackage

// File: rtl/dseqControl.sv
module dseqControl
  import dseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clkQual,
  input  logic                 motorOn,
  input  logic                 readPulse,
  input  logic                 modeLoad,
  input  logic                 modeWrite,
  input  logic                 shiftMsb,
  input  logic [ROM_AW-1:0]    romData,
  output logic [ROM_AW-1:0]    romAddr,
  output seqStrobe_t           strb,
  output logic                 writeData,
  output logic                 illegalCmd
);
  logic [STATE_W-1:0] stateQ;
  logic pulseA, pulseB, pulseEdge, advance;
  logic [3:0] cmd;

  assign advance   = clkQual & motorOn;
  assign pulseEdge = pulseA & ~pulseB;
  assign cmd       = romData[3:0];

  // address order matters: the ROM program is written against it
  assign romAddr = {stateQ[3], stateQ[2], stateQ[0], ~pulseEdge,
                    modeWrite, modeLoad, shiftMsb, stateQ[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              stateQ <= '0;
    else if (!motorOn)      stateQ <= '0;
    else if (advance)       stateQ <= romData[ROM_AW-1:ROM_AW-STATE_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseA <= 1'b0;
      pulseB <= 1'b0;
    end else if (advance) begin
      pulseA <= readPulse;
      pulseB <= pulseA;
    end
  end

  always_comb begin
    strb = '0;
    if (advance) begin
      unique case (cmd)
        CMD_CLR:  strb.clr  = 1'b1;
        CMD_HOLD: ;
        CMD_SL0:  strb.shl  = 1'b1;
        CMD_SL1:  begin strb.shl = 1'b1; strb.ins = 1'b1; end
        CMD_SHR:  strb.shr  = 1'b1;
        CMD_LOAD: strb.load = 1'b1;
        default:  strb.illegal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) illegalCmd <= 1'b0;
    else       illegalCmd <= strb.illegal;
  end

  assign writeData = stateQ[STATE_W-1] & modeWrite;

  AST_NEXT_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (clkQual && motorOn) |=> stateQ == $past(romData[7:4])); // R3
  AST_MOTOR_OFF_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !motorOn |=> stateQ == '0); // R8
  AST_ONE_OP: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clr, strb.shl, strb.shr, strb.load, strb.illegal})); // R4
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    illegalCmd |-> $past(clkQual && motorOn)); // R7
  AST_DETECT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(clkQual && motorOn) |=> $stable(pulseA) && $stable(pulseB)); // R8
endmodule

// File: rtl/dseqDatapath.sv
module dseqDatapath
  import dseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strb,
  input  logic               writeProtect,
  input  logic [SHIFT_W-1:0] busIn,
  output logic [SHIFT_W-1:0] shiftQ
);
  logic [SHIFT_W-1:0] shiftD;

  always_comb begin
    shiftD = shiftQ;
    if (strb.clr)       shiftD = '0;
    else if (strb.shl)  shiftD = {shiftQ[SHIFT_W-2:0], strb.ins};
    else if (strb.shr)  shiftD = {writeProtect, shiftQ[SHIFT_W-1:1]};
    else if (strb.load) shiftD = busIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= shiftD;
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.clr || strb.shl || strb.shr || strb.load) |=> $stable(shiftQ)); // R7
  AST_SHR_FILL: assert property (@(posedge clk) disable iff (!rstN)
    strb.shr |=> shiftQ[SHIFT_W-1] == $past(writeProtect)); // R5
  AST_LOAD_BUS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> shiftQ == $past(busIn)); // R6
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strb.clr |=> shiftQ == '0); // R4
endmodule

// File: rtl/diskSequencer.sv
module diskSequencer
  import dseq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkQual,
  input  logic               motorOn,
  input  logic               readPulse,
  input  logic               writeProtect,
  input  logic               modeLoad,
  input  logic               modeWrite,
  input  logic               devSelect,
  input  logic               addrLsb,
  input  logic [SHIFT_W-1:0] busIn,
  output logic [SHIFT_W-1:0] busOut,
  output logic [ROM_AW-1:0]  romAddr,
  input  logic [ROM_AW-1:0]  romData,
  output logic               writeData,
  output logic               illegalCmd
);
  seqStrobe_t         strb;
  logic [SHIFT_W-1:0] shiftQ;

  dseqControl uCtrl (
    .clk, .rstN, .clkQual, .motorOn, .readPulse, .modeLoad, .modeWrite,
    .shiftMsb(shiftQ[SHIFT_W-1]), .romData, .romAddr, .strb,
    .writeData, .illegalCmd
  );

  dseqDatapath uPath (
    .clk, .rstN, .strb, .writeProtect, .busIn, .shiftQ
  );

  assign busOut = (devSelect && !addrLsb) ? shiftQ : 'z;

  AST_MSB_FEED: assert property (@(posedge clk) disable iff (!rstN)
    romAddr[1] == shiftQ[SHIFT_W-1]); // R2
endmodule

// File: tb/tb_diskSequencer.sv
module tb_diskSequencer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkQual = 0, motorOn = 0, readPulse = 0, writeProtect = 0;
  logic modeLoad = 0, modeWrite = 0, devSelect = 1, addrLsb = 0;
  logic [7:0] busIn = 8'h00;
  wire  [7:0] busOut;
  logic [7:0] romAddr, romData;
  logic writeData, illegalCmd;

  logic [7:0] rom [256];
  int tests = 0, fails = 0;
  bit done = 0;

  logic [3:0] mState = 0;
  logic [7:0] mShift = 0;
  logic mP1 = 0, mP2 = 0, mIll = 0;

  always #4 clk = ~clk;

  assign romData = rom[romAddr];

  diskSequencer dut (
    .clk, .rstN, .clkQual, .motorOn, .readPulse, .writeProtect,
    .modeLoad, .modeWrite, .devSelect, .addrLsb, .busIn, .busOut,
    .romAddr, .romData, .writeData, .illegalCmd
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expAddr();
    return {mState[3], mState[2], mState[0], ~(mP1 & ~mP2),
            modeWrite, modeLoad, mShift[7], mState[1]};
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = 8'((i * 73 + 29) ^ (i >> 3));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state, seen through address, bus and flag
    chk("R1 romAddr after reset", romAddr, 8'h10);
    chk("R1 shift after reset", busOut, 8'h00);
    chk("R1 illegal after reset", illegalCmd, 1'b0);

    for (int n = 0; n < 6000; n++) begin
      logic [31:0] u;
      logic [7:0] a, d, ns;
      logic adv;
      u = 32'(n);
      @(negedge clk);
      clkQual      = (n % 3) != 0;
      motorOn      = (n % 97) >= 5;
      readPulse    = ((n / 5) % 2) == 1;
      modeLoad     = u[6];
      modeWrite    = u[7];
      writeProtect = u[2] ^ u[4];
      busIn        = 8'(n * 13 + 5);
      #1;
      a = expAddr();
      chk("R2 R3 R8 R9 romAddr", romAddr, a);
      chk("R4 R5 R6 R7 shift read via bus", busOut, mShift);
      chk("R11 writeData", writeData, mState[3] & modeWrite);
      chk("R7 illegal flag", illegalCmd, mIll);
      d = rom[a];
      adv = clkQual & motorOn;
      ns = mShift;
      if (adv) begin
        case (d[3:0])
          4'h0: ns = 8'h00;
          4'h8: ns = mShift;
          4'h9: ns = {mShift[6:0], 1'b0};
          4'hD: ns = {mShift[6:0], 1'b1};
          4'hA: ns = {writeProtect, mShift[7:1]};
          4'hB: ns = busIn;
          default: ns = mShift;
        endcase
      end
      mIll = adv && !(d[3:0] inside {4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hD});
      mShift = ns;
      if (!motorOn) mState = 4'h0;
      else if (adv) mState = d[7:4];
      if (adv) begin
        mP2 = mP1;
        mP1 = readPulse;
      end
    end

    @(negedge clk);
    clkQual = 0;
    devSelect = 0; addrLsb = 0;
    #1;
    chk("R10 bus released when deselected", busOut === 8'hzz, 1'b1);
    devSelect = 1; addrLsb = 1;
    #1;
    chk("R10 bus released at odd address", busOut === 8'hzz, 1'b1);
    addrLsb = 0;
    #1;
    chk("R10 bus driven when selected", busOut, mShift);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule